// File: doc/BRIEF.md
# Stereo Audio Transmit Serializer

This block drives the serial data line of a two-channel audio transmit port. Software or a DMA engine pushes stereo sample pairs into a small internal queue over a valid/ready handshake. At the start of every frame the block takes one pair from the queue. It then shifts the left sample during the first half of the frame and the right sample during the second half, most significant bit first. Each half is a slot of fixed width, and the slot may be wider than the sample.

Timing comes from an external clock generator. A one-cycle `bit_tick` strobe marks each bit clock edge on which the data line may change. The frame clock level, sampled at those strobes, tells the two halves apart: low means left and high means right. Three framings are available: the MSB one bit after the frame clock edge, the MSB on the edge, or the LSB on the last bit of the slot. Samples can be 16, 24 or 32 bits wide. The framing and width are latched only when a frame starts. If the queue is empty when a frame starts, the block sends silence and sets a sticky underrun flag.

Top module: `stereo_tx_serializer`

## Requirements
- R1: The width code `cfg_wlen` selects the sample width: 0 gives 16 bits, 1 gives 24 bits, and 2 or 3 give 32 bits. The sample is taken from the low bits of the 32-bit input word, and the bits above it have no effect on the line.
- R2: With `cfg_delay`=1 and `cfg_rjust`=0, the MSB of each half's sample is sent at slot position 1, which is the first bit tick after the frame clock edge. The remaining bits follow MSB first.
- R3: With `cfg_delay`=0 and `cfg_rjust`=0, the MSB is sent at slot position 0, on the tick where the frame clock changes.
- R4: With `cfg_rjust`=1, the sample LSB is sent at the last slot position (`SLOT_W`-1), whatever the value of `cfg_delay`.
- R5: Every slot position that carries no sample bit is driven as 0.
- R6: In the delayed framing with a sample as wide as the slot, the LSB of each half is sent at position 0 of the following half.
- R7: A frame starts at a tick where the frame clock is seen falling to 0. The left half is sent while the frame clock is low and the right half while it is high. Exactly one queued pair is consumed per frame, left sample first.
- R8: While `tx_en` is 0, `sdata` is 0 after every tick, and no pair is consumed and no underrun is raised. After `tx_en` returns to 1, output resumes at the next frame start.
- R9: If the queue is empty at a frame start while enabled, both halves of that frame are all zeros and `underrun` goes to 1. It then stays at 1 until reset.
- R10: The width, delay and justify controls are captured only at a frame start. A change during a frame takes effect from the next frame.
- R11: The queue holds `DEPTH` pairs in arrival order. `s_ready` is 1 exactly when the queue is not full, and a pair offered while it is full is dropped.
- R12: After reset, `sdata`=0, `underrun`=0 and `s_ready`=1, and the line stays 0 until the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit channel enable |
| bit_tick | input | 1 | One-cycle strobe at each bit clock data-change edge |
| frame_clk | input | 1 | Frame clock level (0 = left half, 1 = right half) |
| cfg_wlen | input | 2 | Sample width code |
| cfg_delay | input | 1 | 1 = MSB one bit after the frame clock edge |
| cfg_rjust | input | 1 | 1 = LSB on the last bit of the slot |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Queue can accept a pair |
| s_left | input | 32 | Left sample word |
| s_right | input | 32 | Right sample word |
| sdata | output | 1 | Serial data line, updated on the clock edge that sees `bit_tick` |
| underrun | output | 1 | Sticky: a frame started with an empty queue |

## Verification
The bench builds the block with `SLOT_W`=32 and `DEPTH`=4. Because the slot equals the widest sample, the 32-bit delayed framing pushes each LSB into position 0 of the next half, so the carry path is exercised. The same slot leaves 8 or 16 idle positions for the narrower widths, so zero padding on both sides of the sample can be checked. A four-entry queue fills after a few pushes, which brings the full condition, the dropped fifth pair, the in-order drain and the underrun on the frame after the drain all into a short run.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int SAMPLE_W = 32;

    typedef enum logic [1:0] {
        WL_16   = 2'd0,
        WL_24   = 2'd1,
        WL_32   = 2'd2,
        WL_RSVD = 2'd3
    } stx_wlen_e;

    typedef struct packed {
        stx_wlen_e wlen;
        logic      delay;
        logic      rjust;
    } stx_cfg_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] right;
        logic [SAMPLE_W-1:0] left;
    } stx_pair_t;

    // Sample width in bits for a width code; the reserved code means full width.
    function automatic int wlen_bits(stx_wlen_e w);
        case (w)
            WL_16:   return 16;
            WL_24:   return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/stx_pair_fifo.sv
module stx_pair_fifo
    import stx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  stx_pair_t din,
    input  logic      pop,
    output stx_pair_t dout,
    output logic      full,
    output logic      empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    stx_pair_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic            push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_ADDR) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST_ADDR) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R11: occupancy never exceeds the configured depth
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R11: the frame logic never asks for a pair that is not there
    assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/stx_slot_map.sv
module stx_slot_map
    import stx_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int POS_W  = 5
) (
    input  logic [SAMPLE_W-1:0] word,
    input  stx_cfg_t            cfg,
    input  logic [POS_W-1:0]    pos,
    input  logic                carry_in,
    output logic                bit_out
);

    localparam int IDX_W = $clog2(SAMPLE_W);

    int n, p, lead, k;

    // Picks the line value for one slot position: right-justified samples end on
    // the last position, otherwise the MSB sits at position 0 or 1.
    always_comb begin
        n       = wlen_bits(cfg.wlen);
        p       = int'(pos);
        lead    = SLOT_W - n;
        k       = 0;
        bit_out = 1'b0;
        if (cfg.rjust) begin
            if (p >= lead) begin
                k       = n - 1 - (p - lead);
                bit_out = word[k[IDX_W-1:0]];
            end
        end else if (cfg.delay && p == 0) begin
            bit_out = carry_in;
        end else begin
            k = p - (cfg.delay ? 1 : 0);
            if (k < n) begin
                k       = n - 1 - k;
                bit_out = word[k[IDX_W-1:0]];
            end
        end
    end

endmodule

// File: rtl/stereo_tx_serializer.sv
module stereo_tx_serializer
    import stx_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_en,
    input  logic                bit_tick,
    input  logic                frame_clk,
    input  logic [1:0]          cfg_wlen,
    input  logic                cfg_delay,
    input  logic                cfg_rjust,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                sdata,
    output logic                underrun
);

    localparam int POS_W = $clog2(SLOT_W);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_W - 1);

    // frame state
    logic                lr_q;
    logic                active_q;
    stx_cfg_t            cfg_q;
    logic [SAMPLE_W-1:0] left_q, right_q;
    logic [POS_W-1:0]    pos_q;
    logic                sdata_q, underrun_q;

    // queue
    stx_pair_t fifo_in, fifo_head;
    logic      fifo_full, fifo_empty, push, pop;

    // per-tick decode
    stx_cfg_t            cfg_in, map_cfg;
    logic                half_edge, frame_start, launch;
    logic [SAMPLE_W-1:0] ending_word, map_word;
    logic [POS_W-1:0]    map_pos;
    logic                tail, map_bit;

    assign fifo_in = '{right: s_right, left: s_left};
    assign push    = s_valid && !fifo_full;
    assign s_ready = !fifo_full;

    stx_pair_fifo #(.DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (fifo_in),
        .pop   (pop),
        .dout  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    always_comb begin
        cfg_in      = '{wlen: stx_wlen_e'(cfg_wlen), delay: cfg_delay, rjust: cfg_rjust};
        half_edge   = bit_tick && (frame_clk != lr_q);
        frame_start = half_edge && !frame_clk;
        launch      = frame_start && tx_en;
        pop         = launch && !fifo_empty;
        // Half that is finishing at this edge; its LSB spills over when the
        // delayed framing fills the whole slot.
        ending_word = lr_q ? right_q : left_q;
        tail        = active_q && cfg_q.delay && !cfg_q.rjust &&
                      (wlen_bits(cfg_q.wlen) == SLOT_W) && ending_word[0];
        if (launch)         map_word = fifo_empty ? '0 : fifo_head.left;
        else if (frame_clk) map_word = right_q;
        else                map_word = left_q;
        map_cfg = launch ? cfg_in : cfg_q;
        if (half_edge)              map_pos = '0;
        else if (pos_q == POS_LAST) map_pos = pos_q;
        else                        map_pos = pos_q + 1'b1;
    end

    stx_slot_map #(.SLOT_W(SLOT_W), .POS_W(POS_W)) u_map (
        .word     (map_word),
        .cfg      (map_cfg),
        .pos      (map_pos),
        .carry_in (tail),
        .bit_out  (map_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_q       <= 1'b1;
            active_q   <= 1'b0;
            cfg_q      <= '{wlen: WL_16, delay: 1'b0, rjust: 1'b0};
            left_q     <= '0;
            right_q    <= '0;
            pos_q      <= '0;
            sdata_q    <= 1'b0;
            underrun_q <= 1'b0;
        end else if (bit_tick) begin
            lr_q  <= frame_clk;
            pos_q <= map_pos;
            if (!tx_en) begin
                active_q <= 1'b0;
                sdata_q  <= 1'b0;
            end else if (frame_start) begin
                active_q <= 1'b1;
                cfg_q    <= cfg_in;
                left_q   <= fifo_empty ? '0 : fifo_head.left;
                right_q  <= fifo_empty ? '0 : fifo_head.right;
                if (fifo_empty) underrun_q <= 1'b1;
                sdata_q  <= map_bit;
            end else begin
                sdata_q <= active_q ? map_bit : 1'b0;
            end
        end
    end

    assign sdata    = sdata_q;
    assign underrun = underrun_q;

    // R8: a tick seen while disabled leaves the line low
    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && !tx_en) |=> !sdata);

    // R9: the underrun flag never clears on its own
    assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    // R9: the flag can only rise from an enabled tick with the frame clock low
    assert_underrun_at_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(bit_tick && tx_en && !frame_clk));

    // R10: the captured framing holds for the whole frame
    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(cfg_q));

endmodule

// File: tb/stereo_tx_serializer_bench.sv
module stereo_tx_serializer_bench;
    import stx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 32;
    localparam int DEPTH      = 4;

    logic        clk = 1'b0;
    logic        rst, tx_en, bit_tick, frame_clk;
    logic [1:0]  cfg_wlen;
    logic        cfg_delay, cfg_rjust;
    logic        s_valid, s_ready;
    logic [31:0] s_left, s_right;
    logic        sdata, underrun;

    int   checks = 0;
    int   errors = 0;
    logic done   = 1'b0;
    logic tail_bit = 1'b0;

    stereo_tx_serializer #(.SLOT_W(SLOT), .DEPTH(DEPTH)) u_stereo_tx_serializer (
        .clk(clk), .rst(rst), .tx_en(tx_en), .bit_tick(bit_tick), .frame_clk(frame_clk),
        .cfg_wlen(cfg_wlen), .cfg_delay(cfg_delay), .cfg_rjust(cfg_rjust),
        .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
        .sdata(sdata), .underrun(underrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected slot contents, first-sent bit in bit 31.
    function automatic logic [31:0] slot_of(input logic [31:0] w, input logic [1:0] wl,
                                            input logic d, input logic rj, input logic prev);
        int n;
        logic [31:0] m, body;
        n    = (wl == 2'd0) ? 16 : (wl == 2'd1) ? 24 : 32;
        m    = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        body = w & m;
        if (rj) return body;
        body = body << (32 - n);
        if (d) return {prev, body[31:1]};
        return body;
    endfunction

    function automatic logic carries(input logic [1:0] wl, input logic d, input logic rj);
        return d && !rj && (wl != 2'd0) && (wl != 2'd1);
    endfunction

    task automatic do_tick(input logic lr, output logic b);
        bit_tick  = 1'b1;
        frame_clk = lr;
        @(negedge clk);
        bit_tick  = 1'b0;
        b = sdata;
        @(negedge clk);
    endtask

    task automatic run_half(input logic lr, output logic [31:0] g);
        logic b;
        for (int p = 0; p < SLOT; p++) begin
            do_tick(lr, b);
            g[31-p] = b;
        end
    endtask

    task automatic set_cfg(input logic [1:0] wl, input logic d, input logic rj);
        cfg_wlen = wl; cfg_delay = d; cfg_rjust = rj;
    endtask

    task automatic push_pair(input logic [31:0] l, input logic [31:0] r);
        s_valid = 1'b1; s_left = l; s_right = r;
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    // One frame with the given expected words and framing.
    task automatic frame_expect(input string req, input logic [31:0] l, input logic [31:0] r,
                                input logic [1:0] wl, input logic d, input logic rj);
        logic [31:0] gl, gr;
        logic c;
        c = carries(wl, d, rj);
        run_half(1'b0, gl);
        run_half(1'b1, gr);
        check(req, "left slot",  gl, slot_of(l, wl, d, rj, tail_bit));
        check(req, "right slot", gr, slot_of(r, wl, d, rj, c & l[0]));
        tail_bit = c & r[0];
    endtask

    task automatic t_reset;
        logic b;
        for (int i = 0; i < 3; i++) do_tick(1'b1, b);
        check("R12", "sdata after reset", {31'd0, sdata}, 32'd0);
        check("R12", "underrun after reset", {31'd0, underrun}, 32'd0);
        check("R12", "s_ready after reset", {31'd0, s_ready}, 32'd1);
    endtask

    task automatic t_std32;
        push_pair(32'hA5C3_9E71, 32'h1234_5679);
        push_pair(32'h8000_0001, 32'hFFFF_0003);
        push_pair(32'h0F0F_F0F0, 32'h7654_3211);
        set_cfg(2'd2, 1'b1, 1'b0);
        tail_bit = 1'b0;
        frame_expect("R2 R7", 32'hA5C3_9E71, 32'h1234_5679, 2'd2, 1'b1, 1'b0);
        frame_expect("R6",    32'h8000_0001, 32'hFFFF_0003, 2'd2, 1'b1, 1'b0);
        frame_expect("R6 R1", 32'h0F0F_F0F0, 32'h7654_3211, 2'd2, 1'b1, 1'b0);
    endtask

    task automatic t_lj16;
        push_pair(32'hDEAD_8001, 32'hBEEF_4B2D);
        push_pair(32'hFFFF_0000, 32'h0000_FFFF);
        set_cfg(2'd0, 1'b0, 1'b0);
        frame_expect("R3 R1 R5", 32'hDEAD_8001, 32'hBEEF_4B2D, 2'd0, 1'b0, 1'b0);
        frame_expect("R3 R5",    32'hFFFF_0000, 32'h0000_FFFF, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_rj24_std16;
        push_pair(32'hCC80_0001, 32'h11FE_DCBA);
        push_pair(32'h5555_9ABC, 32'hAAAA_FEDC);
        set_cfg(2'd1, 1'b1, 1'b1);
        frame_expect("R4 R1 R5", 32'hCC80_0001, 32'h11FE_DCBA, 2'd1, 1'b1, 1'b1);
        set_cfg(2'd0, 1'b1, 1'b0);
        frame_expect("R2 R5",    32'h5555_9ABC, 32'hAAAA_FEDC, 2'd0, 1'b1, 1'b0);
    endtask

    task automatic t_disable;
        logic [31:0] gl, gr;
        push_pair(32'h9876_5432, 32'h0BAD_F00D);
        set_cfg(2'd2, 1'b0, 1'b0);
        tx_en = 1'b0;
        run_half(1'b0, gl);
        run_half(1'b1, gr);
        check("R8", "left while disabled",  gl, 32'd0);
        check("R8", "right while disabled", gr, 32'd0);
        check("R8", "no underrun while disabled", {31'd0, underrun}, 32'd0);
        tx_en    = 1'b1;
        tail_bit = 1'b0;
        // the pair offered before the disabled frame must still be queued
        frame_expect("R8", 32'h9876_5432, 32'h0BAD_F00D, 2'd2, 1'b0, 1'b0);
    endtask

    task automatic t_cfg_midframe;
        logic [31:0] gl, gr;
        push_pair(32'hC001_D00D, 32'h3141_5927);
        push_pair(32'h0000_ABCD, 32'h0000_1357);
        set_cfg(2'd2, 1'b1, 1'b0);
        run_half(1'b0, gl);
        set_cfg(2'd0, 1'b0, 1'b1);
        run_half(1'b1, gr);
        check("R10", "left before change", gl, slot_of(32'hC001_D00D, 2'd2, 1'b1, 1'b0, tail_bit));
        check("R10", "right keeps frame framing", gr, slot_of(32'h3141_5927, 2'd2, 1'b1, 1'b0, 1'b1));
        tail_bit = 1'b1;
        frame_expect("R10", 32'h0000_ABCD, 32'h0000_1357, 2'd0, 1'b0, 1'b1);
    endtask

    task automatic t_full_underrun;
        logic [31:0] gl, gr;
        set_cfg(2'd1, 1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++)
            push_pair(32'h0010_0000 + 32'(i), 32'h00A0_0000 + 32'(i));
        check("R11", "s_ready when full", {31'd0, s_ready}, 32'd0);
        push_pair(32'h00EE_EEEE, 32'h00DD_DDDD);
        for (int i = 0; i < DEPTH; i++)
            frame_expect("R11", 32'h0010_0000 + 32'(i), 32'h00A0_0000 + 32'(i), 2'd1, 1'b0, 1'b0);
        check("R11", "s_ready after drain", {31'd0, s_ready}, 32'd1);
        check("R9", "no underrun before empty start", {31'd0, underrun}, 32'd0);
        run_half(1'b0, gl);
        check("R9", "underrun raised", {31'd0, underrun}, 32'd1);
        run_half(1'b1, gr);
        check("R9", "left zeros on underrun",  gl, 32'd0);
        check("R9", "right zeros on underrun", gr, 32'd0);
        push_pair(32'h0012_3456, 32'h0065_4321);
        frame_expect("R9", 32'h0012_3456, 32'h0065_4321, 2'd1, 1'b0, 1'b0);
        check("R9", "underrun stays set", {31'd0, underrun}, 32'd1);
    endtask

    initial begin
        rst = 1'b1; tx_en = 1'b0; bit_tick = 1'b0; frame_clk = 1'b1;
        cfg_wlen = 2'd0; cfg_delay = 1'b0; cfg_rjust = 1'b0;
        s_valid = 1'b0; s_left = '0; s_right = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        tx_en = 1'b1;
        t_std32();
        t_lj16();
        t_rj24_std16();
        t_disable();
        t_cfg_midframe();
        t_full_underrun();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule